// File: doc/BRIEF.md
# Priority Bus Grant Arbiter

This block is the central arbiter of a shared bus on which several devices may ask to become the next master. Devices raise one of four priority request lines, levels 4 to 7, or a separate direct-memory-access request line. The arbiter picks one winner and returns a grant on the line that matches the request. The winning device answers with a selection acknowledge, which marks it as the next master.

Arbitration does not wait for the data lines to be free. A grant can be issued and acknowledged while the current master still holds bus busy. The selected device then waits for bus busy to fall, takes the bus, and releases its acknowledge. The arbiter reports through a registered flag that a selected device is waiting behind a busy bus. The bus-wide initialise input returns the arbiter to idle at once.

Top module: `bus_grant_arbiter`

## Requirements
- R1: A DMA request wins over every priority level. When `dma_req` is high at the grant decision, `dma_gnt` is the grant issued and no bit of `lvl_gnt` rises.
- R2: Without a DMA request, the highest eligible level wins. Bit i of `lvl_req`/`lvl_gnt` is level 4+i, so bit 3 is level 7, the highest. A level is eligible only when its number is strictly greater than `cpu_pri`.
- R3: A level whose number is not above `cpu_pri` is never granted, however long it is requested.
- R4: At most one of the five grant outputs is high at any time. A grant issued from idle appears one clock after the request is sampled. It stays on the same line while a higher request arrives.
- R5: A grant falls one clock after `sel_ack` is sampled high.
- R6: No new grant is issued while `sel_ack` is high. The next grant can appear at the earliest one clock after `sel_ack` is sampled low.
- R7: A grant is issued and acknowledged whatever the state of `bus_busy`, so selection overlaps the current transfer.
- R8: If the granted request line falls before any acknowledge, the grant falls one clock later. The arbiter then returns to idle.
- R9: Reset or `bus_init` clears every grant and `next_wait` on the following clock and returns the arbiter to idle.
- R10: `next_wait` is high, one clock after sampling, exactly while an acknowledged selection is pending and `bus_busy` is high. It is low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_init | input | 1 | Bus-wide initialise, synchronous, clears the arbiter |
| lvl_req | input | NUM_LEVELS | Priority requests, bit i is level BASE_LEVEL+i |
| dma_req | input | 1 | Non-processor (DMA) request |
| cpu_pri | input | PRI_W | Current processor priority |
| sel_ack | input | 1 | Selection acknowledge from the granted device |
| bus_busy | input | 1 | Current master holds the data lines |
| lvl_gnt | output | NUM_LEVELS | Priority grants, one-hot or zero |
| dma_gnt | output | 1 | DMA grant |
| next_wait | output | 1 | A selected master waits for bus busy to fall |

## Verification
The assertions assume that a device raises `sel_ack` only while it holds a grant, and releases it some cycles later. They also assume that all inputs are stable around the clock edge. The bench models one well-behaved device. It changes inputs only on falling edges and raises the acknowledge only after it has seen its grant. Each transaction ends by dropping the acknowledge and the requests together.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_GRANT = 2'd1,
    ST_HOLD  = 2'd2
  } arb_state_t;
endpackage

// File: rtl/arb_level_pick.sv
module arb_level_pick #(
  parameter int NUM_LEVELS = 4,
  parameter int BASE_LEVEL = 4,
  parameter int PRI_W      = 3
) (
  input  logic [NUM_LEVELS-1:0] req,
  input  logic                  dma_req,
  input  logic [PRI_W-1:0]      cpu_pri,
  output logic [NUM_LEVELS-1:0] pick_lvl,
  output logic                  pick_dma,
  output logic                  pick_any
);
  logic [NUM_LEVELS-1:0] elig;

  // each level is eligible only above the processor priority
  for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_elig
    localparam int LVL_NUM = BASE_LEVEL + g;
    assign elig[g] = req[g] && (LVL_NUM > int'(cpu_pri));
  end

  // later (higher) index overrides: highest eligible level wins
  always_comb begin
    pick_lvl = '0;
    for (int i = 0; i < NUM_LEVELS; i++) begin
      if (elig[i]) begin
        pick_lvl    = '0;
        pick_lvl[i] = 1'b1;
      end
    end
    if (dma_req) pick_lvl = '0;
  end

  assign pick_dma = dma_req;
  assign pick_any = dma_req || (|elig);

  always_comb begin
    // R1 / R4: the picked grant is a single line
    a_r4_pick_single: assert ($onehot0({pick_dma, pick_lvl}));
  end
endmodule

// File: rtl/arb_grant_fsm.sv
module arb_grant_fsm
  import arb_pkg::*;
#(
  parameter int NUM_LEVELS = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_init,
  input  logic [NUM_LEVELS-1:0] req,
  input  logic                  dma_req,
  input  logic [NUM_LEVELS-1:0] pick_lvl,
  input  logic                  pick_dma,
  input  logic                  pick_any,
  input  logic                  sel_ack,
  input  logic                  bus_busy,
  output logic [NUM_LEVELS-1:0] gnt_lvl,
  output logic                  gnt_dma,
  output logic                  nxt_wait
);
  arb_state_t state, state_n;
  logic [NUM_LEVELS-1:0] gnt_lvl_n;
  logic                  gnt_dma_n;
  logic                  still_req;

  assign still_req = (|(gnt_lvl & req)) || (gnt_dma && dma_req);

  always_comb begin
    state_n   = state;
    gnt_lvl_n = gnt_lvl;
    gnt_dma_n = gnt_dma;
    unique case (state)
      ST_IDLE: begin
        if (pick_any && !sel_ack) begin
          state_n   = ST_GRANT;
          gnt_lvl_n = pick_lvl;
          gnt_dma_n = pick_dma;
        end
      end
      ST_GRANT: begin
        if (sel_ack) begin
          state_n   = ST_HOLD;
          gnt_lvl_n = '0;
          gnt_dma_n = 1'b0;
        end else if (!still_req) begin
          state_n   = ST_IDLE;
          gnt_lvl_n = '0;
          gnt_dma_n = 1'b0;
        end
      end
      ST_HOLD: begin
        if (!sel_ack) state_n = ST_IDLE;
      end
      default: begin
        state_n   = ST_IDLE;
        gnt_lvl_n = '0;
        gnt_dma_n = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || bus_init) begin
      state    <= ST_IDLE;
      gnt_lvl  <= '0;
      gnt_dma  <= 1'b0;
      nxt_wait <= 1'b0;
    end else begin
      state    <= state_n;
      gnt_lvl  <= gnt_lvl_n;
      gnt_dma  <= gnt_dma_n;
      nxt_wait <= (state_n == ST_HOLD) && bus_busy;
    end
  end

  // R5: acknowledge removes the grant on the next clock
  a_r5_drop_on_ack: assert property (@(posedge clk) disable iff (rst || bus_init)
    ((|{gnt_dma, gnt_lvl}) && sel_ack) |=> !(|{gnt_dma, gnt_lvl}));

  // R6: a grant never rises after a cycle with acknowledge high
  a_r6_no_grant_in_ack: assert property (@(posedge clk) disable iff (rst || bus_init)
    $rose(|{gnt_dma, gnt_lvl}) |-> !$past(sel_ack));

  // R8: withdrawn request loses its grant
  a_r8_withdraw: assert property (@(posedge clk) disable iff (rst || bus_init)
    ((|{gnt_dma, gnt_lvl}) && !sel_ack && !(|({dma_req, req} & {gnt_dma, gnt_lvl})))
      |=> !(|{gnt_dma, gnt_lvl}));

  // R10: waiting flag only after an acknowledge
  a_r10_wait_needs_ack: assert property (@(posedge clk) disable iff (rst || bus_init)
    $rose(nxt_wait) |-> $past(sel_ack) && $past(bus_busy));
endmodule

// File: rtl/bus_grant_arbiter.sv
module bus_grant_arbiter #(
  parameter int NUM_LEVELS = 4,
  parameter int BASE_LEVEL = 4,
  parameter int PRI_W      = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_init,
  input  logic [NUM_LEVELS-1:0] lvl_req,
  input  logic                  dma_req,
  input  logic [PRI_W-1:0]      cpu_pri,
  input  logic                  sel_ack,
  input  logic                  bus_busy,
  output logic [NUM_LEVELS-1:0] lvl_gnt,
  output logic                  dma_gnt,
  output logic                  next_wait
);
  logic [NUM_LEVELS-1:0] pick_lvl;
  logic                  pick_dma;
  logic                  pick_any;

  arb_level_pick #(
    .NUM_LEVELS(NUM_LEVELS),
    .BASE_LEVEL(BASE_LEVEL),
    .PRI_W     (PRI_W)
  ) u_pick (
    .req     (lvl_req),
    .dma_req (dma_req),
    .cpu_pri (cpu_pri),
    .pick_lvl(pick_lvl),
    .pick_dma(pick_dma),
    .pick_any(pick_any)
  );

  arb_grant_fsm #(
    .NUM_LEVELS(NUM_LEVELS)
  ) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .bus_init(bus_init),
    .req     (lvl_req),
    .dma_req (dma_req),
    .pick_lvl(pick_lvl),
    .pick_dma(pick_dma),
    .pick_any(pick_any),
    .sel_ack (sel_ack),
    .bus_busy(bus_busy),
    .gnt_lvl (lvl_gnt),
    .gnt_dma (dma_gnt),
    .nxt_wait(next_wait)
  );

  // R4: one grant at a time
  a_r4_one_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0({dma_gnt, lvl_gnt}));

  // R1: a level grant never rises while DMA was requesting
  a_r1_dma_first: assert property (@(posedge clk) disable iff (rst || bus_init)
    ((|lvl_gnt) && !$past(|lvl_gnt)) |-> !$past(dma_req));

  // R2: a new level grant matches a line that was requested
  a_r2_matching_line: assert property (@(posedge clk) disable iff (rst || bus_init)
    ((|lvl_gnt) && !$past(|lvl_gnt)) |-> (|($past(lvl_req) & lvl_gnt)));

  // R9: initialise clears every grant
  a_r9_init_clears: assert property (@(posedge clk) disable iff (rst)
    bus_init |=> (!(|{dma_gnt, lvl_gnt}) && !next_wait));
endmodule

// File: tb/test_bus_grant_arbiter.sv
module test_bus_grant_arbiter;
  localparam int NL = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_init = 1'b0;
  logic [NL-1:0] lvl_req = '0;
  logic          dma_req = 1'b0;
  logic [2:0]    cpu_pri = 3'd0;
  logic          sel_ack = 1'b0;
  logic          bus_busy = 1'b0;
  logic [NL-1:0] lvl_gnt;
  logic          dma_gnt;
  logic          next_wait;

  int checks = 0;
  int errors = 0;
  logic [NL:0] exp_q[$];
  logic [NL:0] prev_g = '0;
  bit          done = 0;

  always #5 clk = ~clk;

  bus_grant_arbiter i_bus_grant_arbiter (
    .clk(clk), .rst(rst), .bus_init(bus_init), .lvl_req(lvl_req),
    .dma_req(dma_req), .cpu_pri(cpu_pri), .sel_ack(sel_ack),
    .bus_busy(bus_busy), .lvl_gnt(lvl_gnt), .dma_gnt(dma_gnt),
    .next_wait(next_wait)
  );

  function automatic logic [NL:0] grants();
    return {dma_gnt, lvl_gnt};
  endfunction

  task automatic check(input string req, input logic [NL:0] act, input logic [NL:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // monitor: every rising grant is compared with the scoreboard head
  always @(negedge clk) begin
    if (!rst && grants() != '0 && prev_g == '0) begin
      if (exp_q.size() == 0) check("R4 unexpected grant", grants(), '0);
      else check("R1/R2 grant line", grants(), exp_q.pop_front());
    end
    prev_g <= grants();
  end

  task automatic wait_grant(input string req);
    int n = 0;
    while (grants() == '0 && n < 20) begin
      @(negedge clk);
      n++;
    end
    if (n >= 20) check(req, grants(), 5'b11111);
  endtask

  // full handshake: grant, acknowledge, drop, release
  task automatic txn(input logic [NL-1:0] r, input logic d, input logic [2:0] p,
                     input logic [NL:0] exp, input string req);
    exp_q.push_back(exp);
    cpu_pri = p; lvl_req = r; dma_req = d;
    @(negedge clk);
    check({req, " grant one clock after request (R4)"}, grants(), exp);
    wait_grant(req);
    sel_ack = 1'b1;
    @(negedge clk);
    check("R5 grant drops after ack", grants(), '0);
    repeat (3) begin
      @(negedge clk);
      check("R6 no grant during ack", grants(), '0);
    end
    sel_ack = 1'b0; lvl_req = '0; dma_req = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R9 reset state", grants(), '0);
    checks++;
    if (next_wait !== 1'b0) begin errors++; $display("FAIL R9 next_wait actual=%b expected=0", next_wait); end

    txn(4'b0010, 1'b0, 3'd0, 5'b00010, "R2 single level5");
    txn(4'b1111, 1'b0, 3'd0, 5'b01000, "R2 all levels");
    txn(4'b1000, 1'b1, 3'd0, 5'b10000, "R1 dma over level7");
    txn(4'b0011, 1'b0, 3'd4, 5'b00010, "R2 threshold pri4");

    // R3: level 5 at priority 5 is never granted
    cpu_pri = 3'd5; lvl_req = 4'b0010;
    repeat (10) begin
      @(negedge clk);
      check("R3 blocked level", grants(), '0);
    end
    lvl_req = '0; @(negedge clk);

    // R4: no preemption by a later higher request
    exp_q.push_back(5'b00001);
    cpu_pri = 3'd0; lvl_req = 4'b0001;
    @(negedge clk);
    lvl_req = 4'b1001;
    repeat (3) @(negedge clk);
    check("R4 grant held on level4", grants(), 5'b00001);
    // R8: withdrawal of the granted line
    lvl_req = 4'b1000;
    @(negedge clk);
    check("R8 grant drops on withdraw", grants(), '0);
    exp_q.push_back(5'b01000);
    @(negedge clk);
    check("R8 idle then level7", grants(), 5'b01000);
    sel_ack = 1'b1; @(negedge clk);
    sel_ack = 1'b0; lvl_req = '0; repeat (2) @(negedge clk);

    // R7 / R10: overlap with a busy bus
    bus_busy = 1'b1;
    exp_q.push_back(5'b00100);
    lvl_req = 4'b0100;
    @(negedge clk);
    check("R7 grant while busy", grants(), 5'b00100);
    sel_ack = 1'b1;
    @(negedge clk);
    check("R7 ack accepted while busy", grants(), '0);
    checks++;
    if (next_wait !== 1'b1) begin errors++; $display("FAIL R10 next_wait actual=%b expected=1", next_wait); end
    bus_busy = 1'b0;
    @(negedge clk);
    checks++;
    if (next_wait !== 1'b0) begin errors++; $display("FAIL R10 next_wait actual=%b expected=0", next_wait); end
    bus_busy = 1'b1; lvl_req = '0;
    sel_ack = 1'b0;
    repeat (2) @(negedge clk);
    bus_busy = 1'b0;

    // R9: initialise during an active grant
    exp_q.push_back(5'b00001);
    lvl_req = 4'b0001;
    @(negedge clk);
    check("R9 grant before init", grants(), 5'b00001);
    bus_init = 1'b1;
    @(negedge clk);
    check("R9 init clears grant", grants(), '0);
    exp_q.push_back(5'b00001);
    bus_init = 1'b0;
    @(negedge clk);
    check("R9 regrant after init", grants(), 5'b00001);
    lvl_req = '0;
    repeat (2) @(negedge clk);

    checks++;
    if (exp_q.size() != 0) begin errors++; $display("FAIL R4 missing grants actual=%0d expected=0", exp_q.size()); end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule